// File: doc/BRIEF.md
# Dual-Clock FIFO With Programmable Level Flags

This block carries 36-bit words from a write clock domain into a read clock domain through a 256-entry buffer. Each side has its own clock, its own synchronous active-high reset, an active-high enable and an active-low select. A word moves on a rising edge only when the enable is high and the select is low. The write and read pointers cross between the domains as gray codes through two-flop synchronizers. Because of this, each side's view of the other side is a few cycles old, and every flag errs toward "busier than it really is".

Two timing modes are available. The mode is captured while reset is held and must not change afterwards. In standard mode a read request fetches the next word into the output register on that edge, and the status pins report empty and full. In fall-through mode a one-word output register is refilled from the buffer without any request. The read status pin then means "a word is waiting on the data output", and the write status pin means "the buffer can take a word". In both modes there is an active-low almost-empty pin and an active-low almost-full pin, and each compares a level against an offset that is loaded at reset.

Top module: `dual_clk_fifo`

## Requirements
- R1: A write or read is accepted on a rising edge only when that port's enable is 1 and its select is 0. With the select at 1 nothing is stored or consumed.
- R2: In standard mode (mode input 1), r_stat is 1 exactly when the read side sees no unread word. A read accepted at an edge puts the oldest word on r_data after that edge, and words leave in write order.
- R3: In standard mode w_stat is 1 when 256 words are held, and 0 otherwise.
- R4: In fall-through mode (mode input 0), r_stat is 1 when r_data already holds the oldest unread word, without any read request. That word and r_stat stay unchanged until a read is accepted, and the read consumes it.
- R5: In fall-through mode w_stat is 1 when the buffer has a free location. Counting the output register, 257 words can be held before w_stat drops to 0.
- R6: r_aempty_n is 0 when the number of unread words is less than or equal to the almost-empty offset, and 1 otherwise. In fall-through mode the count includes a word held in the output register.
- R7: w_afull_n is 0 when the number of free buffer locations is less than or equal to the almost-full offset, and 1 otherwise.
- R8: A write while the buffer is full is ignored, and so is a read while nothing is available. Neither moves a pointer, so the stored sequence and r_data are unchanged.
- R9: The mode and both offsets are captured while reset is high. After reset no word is readable, the buffer is not full, r_aempty_n is 0 and w_afull_n is 1.
- R10: Each pointer sent across domains changes in at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Write-side synchronous reset, active high |
| w_en | input | 1 | Write enable, active high |
| w_sel_n | input | 1 | Write select, active low |
| w_data | input | 36 | Write data |
| af_offset | input | 9 | Almost-full offset, captured during wrst |
| w_stat | output | 1 | Full in standard mode, space-available in fall-through mode |
| w_afull_n | output | 1 | Almost-full, active low |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Read-side synchronous reset, active high |
| mode_std | input | 1 | 1 selects standard mode, 0 selects fall-through; captured during reset |
| r_en | input | 1 | Read enable, active high |
| r_sel_n | input | 1 | Read select, active low |
| ae_offset | input | 9 | Almost-empty offset, captured during rrst |
| r_data | output | 36 | Read data register |
| r_stat | output | 1 | Empty in standard mode, output-valid in fall-through mode |
| r_aempty_n | output | 1 | Almost-empty, active low |

## Verification
Several properties are checked on every clock. A blocked write or read leaves its gray pointer unchanged, and each gray pointer steps by at most one bit. Empty implies almost-empty, and full implies almost-full. A waiting fall-through word and its valid flag hold until a read takes it. Other behaviour can only be shown by the bench's scenarios in both modes: the order of the data, the exact threshold boundaries of both almost flags, the 256- and 257-word capacities, and the state after reset.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic {
        MODE_FWFT = 1'b0,
        MODE_STD  = 1'b1
    } tmode_e;

    localparam int DCF_DATA_W = 36;
    localparam int DCF_DEPTH  = 256;
    localparam int DCF_SYNC_N = 2;

    function automatic logic port_go(input logic en, input logic sel_n);
        return en & ~sel_n;
    endfunction

endpackage

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int N = 1 << AW;

    logic [DW-1:0] ram [N];

    always_ff @(posedge wclk) begin
        if (we) ram[waddr] <= wdata;
    end

    assign rdata = ram[raddr];
endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic        wclk,
    input  logic        wrst,
    input  logic        mode_in,
    input  logic        en,
    input  logic        sel_n,
    input  logic [AW:0] af_off_in,
    input  logic [AW:0] rgray_s,
    output logic        we,
    output logic [AW-1:0] waddr,
    output logic [AW:0] wgray,
    output logic        full,
    output logic        w_stat,
    output logic        w_afull_n
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] CAP = PW'(1 << AW);

    tmode_e        mode_q;
    logic [PW-1:0] off_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] used;
    logic [PW-1:0] free_cnt;

    always_comb begin
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
    end

    assign used     = wbin - rbin_s;
    assign full     = used[AW];
    assign free_cnt = CAP - used;
    assign we       = port_go(en, sel_n) & ~full;
    assign waddr    = wbin[AW-1:0];
    assign wbin_nx  = wbin + PW'(1);

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin   <= '0;
            wgray  <= '0;
            mode_q <= tmode_e'(mode_in);
            off_q  <= af_off_in;
        end else if (we) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    assign w_stat    = (mode_q == MODE_STD) ? full : ~full;
    assign w_afull_n = ~(free_cnt <= off_q);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input  logic          rclk,
    input  logic          rrst,
    input  logic          mode_in,
    input  logic          en,
    input  logic          sel_n,
    input  logic [AW:0]   ae_off_in,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] r_data,
    output logic          mem_empty,
    output logic          mode_std_o,
    output logic          r_stat,
    output logic          r_aempty_n
);
    localparam int PW = AW + 1;

    tmode_e        mode_q;
    logic [PW-1:0] off_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] mem_cnt;
    logic [PW-1:0] unread;
    logic          ovalid;
    logic          req;
    logic          is_std;
    logic          take;
    logic          load;
    logic          advance;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    assign is_std    = (mode_q == MODE_STD);
    assign mem_cnt   = wbin_s - rbin;
    assign mem_empty = (mem_cnt == '0);
    assign req       = port_go(en, sel_n);
    assign take      = ~is_std & req & ovalid;
    assign load      = ~is_std & ~mem_empty & (~ovalid | take);
    assign advance   = is_std ? (req & ~mem_empty) : load;
    assign rbin_nx   = rbin + PW'(1);
    assign raddr     = rbin[AW-1:0];

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin   <= '0;
            rgray  <= '0;
            ovalid <= 1'b0;
            r_data <= '0;
            mode_q <= tmode_e'(mode_in);
            off_q  <= ae_off_in;
        end else begin
            if (advance) begin
                rbin   <= rbin_nx;
                rgray  <= rbin_nx ^ (rbin_nx >> 1);
                r_data <= mem_rdata;
            end
            if (!is_std) ovalid <= load | (ovalid & ~take);
        end
    end

    assign unread     = mem_cnt + PW'(ovalid & ~is_std);
    assign r_stat     = is_std ? mem_empty : ovalid;
    assign r_aempty_n = ~(unread <= off_q);
    assign mode_std_o = is_std;
endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo
    import dcf_pkg::*;
#(
    parameter int DW    = DCF_DATA_W,
    parameter int DEPTH = DCF_DEPTH,
    parameter int SYNCN = DCF_SYNC_N
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          w_en,
    input  logic          w_sel_n,
    input  logic [DW-1:0] w_data,
    input  logic [$clog2(DEPTH):0] af_offset,
    output logic          w_stat,
    output logic          w_afull_n,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          mode_std,
    input  logic          r_en,
    input  logic          r_sel_n,
    input  logic [$clog2(DEPTH):0] ae_offset,
    output logic [DW-1:0] r_data,
    output logic          r_stat,
    output logic          r_aempty_n
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_we;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] mem_q;
    logic [AW:0]   wr_gray;
    logic [AW:0]   rd_gray;
    logic [AW:0]   wr_gray_at_r;
    logic [AW:0]   rd_gray_at_w;
    logic          wr_full;
    logic          rd_mem_empty;
    logic          rd_mode_std;

    dcf_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wclk), .we(wr_we), .waddr(wr_addr), .wdata(w_data),
        .raddr(rd_addr), .rdata(mem_q)
    );

    dcf_sync #(.W(AW+1), .STAGES(SYNCN)) u_sync_w2r (
        .clk(rclk), .rst(rrst), .d(wr_gray), .q(wr_gray_at_r)
    );

    dcf_sync #(.W(AW+1), .STAGES(SYNCN)) u_sync_r2w (
        .clk(wclk), .rst(wrst), .d(rd_gray), .q(rd_gray_at_w)
    );

    dcf_wr_side #(.AW(AW)) u_wr (
        .wclk(wclk), .wrst(wrst), .mode_in(mode_std), .en(w_en), .sel_n(w_sel_n),
        .af_off_in(af_offset), .rgray_s(rd_gray_at_w), .we(wr_we), .waddr(wr_addr),
        .wgray(wr_gray), .full(wr_full), .w_stat(w_stat), .w_afull_n(w_afull_n)
    );

    dcf_rd_side #(.DW(DW), .AW(AW)) u_rd (
        .rclk(rclk), .rrst(rrst), .mode_in(mode_std), .en(r_en), .sel_n(r_sel_n),
        .ae_off_in(ae_offset), .wgray_s(wr_gray_at_r), .mem_rdata(mem_q),
        .raddr(rd_addr), .rgray(rd_gray), .r_data(r_data), .mem_empty(rd_mem_empty),
        .mode_std_o(rd_mode_std), .r_stat(r_stat), .r_aempty_n(r_aempty_n)
    );
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input logic          wclk,
    input logic          wrst,
    input logic          rclk,
    input logic          rrst,
    input logic          w_en,
    input logic          w_sel_n,
    input logic          r_en,
    input logic          r_sel_n,
    input logic          wr_full,
    input logic [AW:0]   wr_gray,
    input logic [AW:0]   rd_gray,
    input logic          rd_mem_empty,
    input logic          rd_mode_std,
    input logic          r_stat,
    input logic          r_aempty_n,
    input logic          w_afull_n,
    input logic [DW-1:0] r_data
);
    a_r8_full_write_ignored: assert property (@(posedge wclk) disable iff (wrst)
        (wr_full && w_en && !w_sel_n) |=> $stable(wr_gray));

    a_r8_empty_read_ignored: assert property (@(posedge rclk) disable iff (rrst)
        (rd_mode_std && rd_mem_empty && r_en && !r_sel_n) |=> $stable(rd_gray));

    a_r10_wgray_step: assert property (@(posedge wclk) disable iff (wrst)
        $onehot0(wr_gray ^ $past(wr_gray)));

    a_r10_rgray_step: assert property (@(posedge rclk) disable iff (rrst)
        $onehot0(rd_gray ^ $past(rd_gray)));

    a_r6_empty_is_almost: assert property (@(posedge rclk) disable iff (rrst)
        (rd_mode_std && r_stat) |-> !r_aempty_n);

    a_r7_full_is_almost: assert property (@(posedge wclk) disable iff (wrst)
        wr_full |-> !w_afull_n);

    a_r4_word_held: assert property (@(posedge rclk) disable iff (rrst)
        (!rd_mode_std && r_stat && !(r_en && !r_sel_n)) |=> (r_stat && $stable(r_data)));
endmodule

bind dual_clk_fifo dcf_checker #(.DW(DW), .AW(AW)) u_chk (
    .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst),
    .w_en(w_en), .w_sel_n(w_sel_n), .r_en(r_en), .r_sel_n(r_sel_n),
    .wr_full(wr_full), .wr_gray(wr_gray), .rd_gray(rd_gray),
    .rd_mem_empty(rd_mem_empty), .rd_mode_std(rd_mode_std),
    .r_stat(r_stat), .r_aempty_n(r_aempty_n), .w_afull_n(w_afull_n), .r_data(r_data)
);

// File: tb/dual_clk_fifo_tb_top.sv
module dual_clk_fifo_tb_top;
    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        wrst = 1'b1;
    logic        rrst = 1'b1;
    logic        w_en = 1'b0;
    logic        w_sel_n = 1'b1;
    logic [35:0] w_data = '0;
    logic [8:0]  af_offset = '0;
    logic        w_stat;
    logic        w_afull_n;
    logic        mode_std = 1'b1;
    logic        r_en = 1'b0;
    logic        r_sel_n = 1'b1;
    logic [8:0]  ae_offset = '0;
    logic [35:0] r_data;
    logic        r_stat;
    logic        r_aempty_n;

    int          n_chk = 0;
    int          n_bad = 0;
    int          wd_cnt = 0;
    logic [35:0] sb_q[$];
    logic [35:0] last_rd;

    dual_clk_fifo dut_i (
        .wclk(wclk), .wrst(wrst), .w_en(w_en), .w_sel_n(w_sel_n), .w_data(w_data),
        .af_offset(af_offset), .w_stat(w_stat), .w_afull_n(w_afull_n),
        .rclk(rclk), .rrst(rrst), .mode_std(mode_std), .r_en(r_en), .r_sel_n(r_sel_n),
        .ae_offset(ae_offset), .r_data(r_data), .r_stat(r_stat), .r_aempty_n(r_aempty_n)
    );

    always #5 wclk = ~wclk;
    initial begin
        #3;
        forever #5 rclk = ~rclk;
    end

    task automatic check(input bit ok, input string req, input logic [35:0] act,
                         input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (10) @(negedge rclk);
        @(negedge wclk);
    endtask

    task automatic do_reset(input logic m, input logic [8:0] ae, input logic [8:0] af);
        mode_std = m; ae_offset = ae; af_offset = af;
        wrst = 1'b1; rrst = 1'b1;
        repeat (4) @(negedge wclk);
        repeat (2) @(negedge rclk);
        wrst = 1'b0; rrst = 1'b0;
        sb_q.delete();
        settle();
    endtask

    function automatic bit w_space();
        return mode_std ? !w_stat : w_stat;
    endfunction

    task automatic drive_write(input logic [35:0] d);
        @(negedge wclk);
        while (!w_space()) @(negedge wclk);
        w_en = 1'b1; w_sel_n = 1'b0; w_data = d;
        @(negedge wclk);
        w_en = 1'b0; w_sel_n = 1'b1;
        sb_q.push_back(d);
    endtask

    task automatic monitor_pop(input string req);
        logic [35:0] exp;
        @(negedge rclk);
        if (mode_std) begin
            while (r_stat) @(negedge rclk);
            r_en = 1'b1; r_sel_n = 1'b0;
            @(negedge rclk);
            r_en = 1'b0; r_sel_n = 1'b1;
            exp = sb_q.pop_front();
            check(r_data === exp, req, r_data, exp);
        end else begin
            while (!r_stat) @(negedge rclk);
            exp = sb_q.pop_front();
            check(r_data === exp, req, r_data, exp);
            r_en = 1'b1; r_sel_n = 1'b0;
            @(negedge rclk);
            r_en = 1'b0; r_sel_n = 1'b1;
        end
    endtask

    always @(posedge wclk) begin
        wd_cnt++;
        if (wd_cnt > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", wd_cnt);
            $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        // ---------------- standard mode ----------------
        do_reset(1'b1, 9'd2, 9'd3);
        check(r_stat === 1'b1, "R9 empty", 36'(r_stat), 36'd1);
        check(w_stat === 1'b0, "R9 not full", 36'(w_stat), 36'd0);
        check(r_aempty_n === 1'b0, "R9 aempty", 36'(r_aempty_n), 36'd0);
        check(w_afull_n === 1'b1, "R9 afull", 36'(w_afull_n), 36'd1);

        // R1: enable with select high stores nothing
        @(negedge wclk); w_en = 1'b1; w_sel_n = 1'b1; w_data = 36'hF00;
        @(negedge wclk); w_en = 1'b0;
        settle();
        check(r_stat === 1'b1, "R1 sel blocks write", 36'(r_stat), 36'd1);

        // R8: read while empty leaves r_data
        @(negedge rclk); r_en = 1'b1; r_sel_n = 1'b0;
        @(negedge rclk); r_en = 1'b0; r_sel_n = 1'b1;
        check(r_data === 36'd0, "R8 empty read", r_data, 36'd0);

        drive_write(36'h1_1111_0001);
        drive_write(36'h2_2222_0002);
        settle();
        check(r_aempty_n === 1'b0, "R6 count2 le off2", 36'(r_aempty_n), 36'd0);
        drive_write(36'h3_3333_0003);
        settle();
        check(r_aempty_n === 1'b1, "R6 count3 gt off2", 36'(r_aempty_n), 36'd1);
        check(r_stat === 1'b0, "R2 not empty", 36'(r_stat), 36'd0);

        // R1: read with select high consumes nothing
        @(negedge rclk); r_en = 1'b1; r_sel_n = 1'b1;
        @(negedge rclk); r_en = 1'b0;
        check(r_data === 36'd0, "R1 sel blocks read", r_data, 36'd0);

        for (int i = 0; i < 3; i++) monitor_pop("R2 order");
        settle();
        check(r_stat === 1'b1, "R2 empty again", 36'(r_stat), 36'd1);

        for (int i = 0; i < 252; i++) drive_write(36'(i * 13 + 36'h100));
        settle();
        check(w_afull_n === 1'b1, "R7 free4 gt off3", 36'(w_afull_n), 36'd1);
        check(w_stat === 1'b0, "R3 not full", 36'(w_stat), 36'd0);
        drive_write(36'hA_0000_0001);
        settle();
        check(w_afull_n === 1'b0, "R7 free3 le off3", 36'(w_afull_n), 36'd0);
        for (int i = 0; i < 3; i++) drive_write(36'(36'hB_0000_0000 + i));
        settle();
        check(w_stat === 1'b1, "R3 full", 36'(w_stat), 36'd1);

        // R8: write while full dropped
        @(negedge wclk); w_en = 1'b1; w_sel_n = 1'b0; w_data = 36'hBAD;
        @(negedge wclk); w_en = 1'b0; w_sel_n = 1'b1;
        for (int i = 0; i < 256; i++) monitor_pop("R8 R2 drain");
        settle();
        check(r_stat === 1'b1, "R8 no extra word", 36'(r_stat), 36'd1);

        // ---------------- fall-through mode ----------------
        do_reset(1'b0, 9'd1, 9'd0);
        check(r_stat === 1'b0, "R9 no valid", 36'(r_stat), 36'd0);
        check(w_stat === 1'b1, "R9 space", 36'(w_stat), 36'd1);
        check(r_aempty_n === 1'b0, "R9 aempty fwft", 36'(r_aempty_n), 36'd0);
        check(w_afull_n === 1'b1, "R9 afull fwft", 36'(w_afull_n), 36'd1);

        drive_write(36'h0_0000_1234);
        settle();
        check(r_stat === 1'b1, "R4 valid", 36'(r_stat), 36'd1);
        check(r_data === 36'h0_0000_1234, "R4 fall through", r_data, 36'h1234);
        check(r_aempty_n === 1'b0, "R6 count1 le off1", 36'(r_aempty_n), 36'd0);
        drive_write(36'h0_0000_5678);
        settle();
        check(r_aempty_n === 1'b1, "R6 count2 gt off1", 36'(r_aempty_n), 36'd1);
        check(r_data === 36'h0_0000_1234, "R4 held", r_data, 36'h1234);
        monitor_pop("R4 pop1");
        monitor_pop("R4 pop2");
        settle();
        check(r_stat === 1'b0, "R4 drained", 36'(r_stat), 36'd0);
        last_rd = r_data;
        @(negedge rclk); r_en = 1'b1; r_sel_n = 1'b0;
        @(negedge rclk); r_en = 1'b0; r_sel_n = 1'b1;
        settle();
        check(r_data === last_rd, "R8 read without valid", r_data, last_rd);

        for (int i = 0; i < 256; i++) drive_write(36'(i * 7 + 36'h5_0000_0000));
        settle();
        check(w_stat === 1'b1, "R5 space at 256", 36'(w_stat), 36'd1);
        check(w_afull_n === 1'b1, "R7 free1 gt off0", 36'(w_afull_n), 36'd1);
        drive_write(36'h7_7777_7777);
        settle();
        check(w_stat === 1'b0, "R5 no space at 257", 36'(w_stat), 36'd0);
        check(w_afull_n === 1'b0, "R7 free0 le off0", 36'(w_afull_n), 36'd0);
        for (int i = 0; i < 257; i++) monitor_pop("R5 R4 drain");
        settle();
        check(r_stat === 1'b0, "R5 empty after drain", 36'(r_stat), 36'd0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule